// File: doc/BRIEF.md
# Dual-Port Memory Contention Arbiter

This block is a clocked model of the collision logic that sits in front of a memory with two independent access ports, called left and right. Each port has an address, an active-low chip enable, a write strobe and two active-low byte-lane enables. The storage is a small word array inside the block. When both ports are enabled on the same word and at least one of them is writing, an arbiter picks one port as owner. The other port receives a busy flag, and its writes to the array are suppressed for as long as the collision lasts.

A strap input selects the role. In the master role the arbiter drives each port's busy flag, so it can steer wider arrays built from several copies. In the slave role the busy outputs are held low. Each port then obeys an externally supplied busy input, which suppresses that port's writes. Several copies can therefore share one arbitration decision when they are cascaded side by side to widen the data word. Busy outputs are always driven to a defined level; none of them floats.

Reads are combinational: each port's read data always shows the word currently stored at that port's address. This holds while the port is flagged busy, and a write in the same cycle becomes visible only after the next clock edge.

Top module: `twin_port_guard`

## Requirements
- R1: While `rst` is high on a clock edge, every word of the array is cleared to zero and the ownership state is cleared. After reset, both read outputs return zero for every address, and both busy outputs are low.
- R2: Two enabled ports that both read (`x_write` low) the same address raise no busy flag on either side.
- R3: A collision exists when both chip enables are low, the addresses are equal, and at least one port has `x_write` high. In the master role (`is_master` high), exactly one busy output is high during a collision, in the same cycle.
- R4: The first-arriving port wins. A port has arrived when it was enabled at the same address on the previous clock edge; the other port then gets busy. This applies whether the collision began because an enable went low or because an address changed to match. Ownership is held for every cycle the collision lasts.
- R5: If both ports arrived, or neither did, when a collision begins, the left port wins and `r_busy_o` goes high.
- R6: A busy output drops in the first cycle in which the collision condition of R3 no longer holds.
- R7: A write from a port that is busy leaves the array unchanged, and that port's read data keeps showing the stored word.
- R8: In the slave role (`is_master` low), both busy outputs are low. A high `l_busy_i` or `r_busy_i` suppresses every write from that port.
- R9: In the slave role, if both ports write the same address in the same cycle, the right port's enabled byte lanes take precedence over the left port's.
- R10: `x_ub_n` low writes data bits 15:8 and `x_lb_n` low writes bits 7:0. A lane whose enable is high keeps its stored value.
- R11: `x_rdata` equals the word stored at `x_addr` before the current clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| is_master | input | 1 | Role strap: 1 = arbiter drives busy, 0 = busy comes from inputs |
| l_ce_n | input | 1 | Left chip enable, active low |
| l_write | input | 1 | Left write strobe, 1 = write |
| l_ub_n | input | 1 | Left upper-lane enable, active low |
| l_lb_n | input | 1 | Left lower-lane enable, active low |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | 2*LANE_W | Left write data |
| l_rdata | output | 2*LANE_W | Left read data |
| l_busy_i | input | 1 | Left external busy, used in the slave role |
| l_busy_o | output | 1 | Left busy flag from the arbiter |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_write | input | 1 | Right write strobe, 1 = write |
| r_ub_n | input | 1 | Right upper-lane enable, active low |
| r_lb_n | input | 1 | Right lower-lane enable, active low |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | 2*LANE_W | Right write data |
| r_rdata | output | 2*LANE_W | Right read data |
| r_busy_i | input | 1 | Right external busy, used in the slave role |
| r_busy_o | output | 1 | Right busy flag from the arbiter |

## Verification
A wrong ownership register shows up directly as a flipped or missing busy flag in the same cycle of a collision, or a cycle later as a winner that changes partway through a collision. A stale arrival history shows up in the first cycle of a new collision, when the wrong side is flagged. A write gate that leaks, or a lane-mask fault, corrupts a stored word. That fault becomes visible on the read data one clock edge later, as soon as either port addresses the word. For this reason the reference model compares both busy flags and both read words in every cycle.

// File: rtl/twin_port_pkg.sv
package twin_port_pkg;

    localparam int LANE_COUNT = 2;

    typedef enum logic [1:0] {
        SIDE_NONE  = 2'd0,
        SIDE_LEFT  = 2'd1,
        SIDE_RIGHT = 2'd2
    } side_e;

    typedef struct packed {
        logic                  en;
        logic                  wr;
        logic [LANE_COUNT-1:0] lanes;
    } port_ctl_t;

    function automatic port_ctl_t decode_ctl(input logic ce_n, input logic write,
                                             input logic ub_n, input logic lb_n);
        port_ctl_t c;
        c.en    = ~ce_n;
        c.wr    = write;
        c.lanes = {~ub_n, ~lb_n};
        return c;
    endfunction

    function automatic side_e first_arrival(input logic l_settled, input logic r_settled);
        if (r_settled && !l_settled) return SIDE_RIGHT;
        return SIDE_LEFT;
    endfunction

endpackage

// File: rtl/tp_port_track.sv
module tp_port_track #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output logic              settled
);
    logic              en_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            addr_q <= '0;
        end else begin
            en_q   <= en;
            addr_q <= addr;
        end
    end

    assign settled = en && en_q && (addr_q == addr);
endmodule

// File: rtl/tp_arbiter.sv
module tp_arbiter
    import twin_port_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic master,
    input  logic l_en,
    input  logic r_en,
    input  logic l_wr,
    input  logic r_wr,
    input  logic same_addr,
    input  logic l_settled,
    input  logic r_settled,
    output logic l_lose,
    output logic r_lose
);
    side_e owner_q;
    side_e winner;
    logic  contend;

    always_comb begin
        contend = l_en && r_en && same_addr && (l_wr || r_wr);
        if (!contend)
            winner = SIDE_NONE;
        else if (owner_q != SIDE_NONE)
            winner = owner_q;
        else
            winner = first_arrival(l_settled, r_settled);
    end

    always_ff @(posedge clk) begin
        if (rst) owner_q <= SIDE_NONE;
        else     owner_q <= winner;
    end

    assign l_lose = master && (winner == SIDE_RIGHT);
    assign r_lose = master && (winner == SIDE_LEFT);

    // R4: once a collision is decided, the owner does not change while it lasts
    assert_hold_winner_R4: assert property (@(posedge clk) disable iff (rst)
        (contend && $past(contend) && !$past(rst)) |-> (winner == $past(winner)));
endmodule

// File: rtl/tp_byte_mem.sv
module tp_byte_mem
    import twin_port_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANE_W = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         l_we,
    input  logic [LANE_COUNT-1:0]        l_mask,
    input  logic [ADDR_W-1:0]            l_addr,
    input  logic [LANE_COUNT*LANE_W-1:0] l_wdata,
    output logic [LANE_COUNT*LANE_W-1:0] l_rdata,
    input  logic                         r_we,
    input  logic [LANE_COUNT-1:0]        r_mask,
    input  logic [ADDR_W-1:0]            r_addr,
    input  logic [LANE_COUNT*LANE_W-1:0] r_wdata,
    output logic [LANE_COUNT*LANE_W-1:0] r_rdata
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int WORD_W = LANE_COUNT * LANE_W;

    logic [WORD_W-1:0] store [DEPTH];
    logic [WORD_W-1:0] l_bits, r_bits;

    // expand lane masks into per-bit masks
    for (genvar g = 0; g < LANE_COUNT; g++) begin : g_lane
        assign l_bits[g*LANE_W +: LANE_W] = {LANE_W{l_we && l_mask[g]}};
        assign r_bits[g*LANE_W +: LANE_W] = {LANE_W{r_we && r_mask[g]}};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) store[i] <= '0;
        end else if (l_addr == r_addr) begin
            // right lanes overwrite left lanes on a shared word
            store[l_addr] <= (store[l_addr] & ~(l_bits | r_bits))
                           | (l_wdata & l_bits & ~r_bits)
                           | (r_wdata & r_bits);
        end else begin
            store[l_addr] <= (store[l_addr] & ~l_bits) | (l_wdata & l_bits);
            store[r_addr] <= (store[r_addr] & ~r_bits) | (r_wdata & r_bits);
        end
    end

    assign l_rdata = store[l_addr];
    assign r_rdata = store[r_addr];
endmodule

// File: rtl/twin_port_guard.sv
module twin_port_guard
    import twin_port_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANE_W = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         is_master,
    input  logic                         l_ce_n,
    input  logic                         l_write,
    input  logic                         l_ub_n,
    input  logic                         l_lb_n,
    input  logic [ADDR_W-1:0]            l_addr,
    input  logic [LANE_COUNT*LANE_W-1:0] l_wdata,
    output logic [LANE_COUNT*LANE_W-1:0] l_rdata,
    input  logic                         l_busy_i,
    output logic                         l_busy_o,
    input  logic                         r_ce_n,
    input  logic                         r_write,
    input  logic                         r_ub_n,
    input  logic                         r_lb_n,
    input  logic [ADDR_W-1:0]            r_addr,
    input  logic [LANE_COUNT*LANE_W-1:0] r_wdata,
    output logic [LANE_COUNT*LANE_W-1:0] r_rdata,
    input  logic                         r_busy_i,
    output logic                         r_busy_o
);
    port_ctl_t         ctl  [2];
    logic [ADDR_W-1:0] addr [2];
    logic              settled [2];
    logic              l_lose, r_lose, l_block, r_block;

    always_comb begin
        ctl[0]  = decode_ctl(l_ce_n, l_write, l_ub_n, l_lb_n);
        ctl[1]  = decode_ctl(r_ce_n, r_write, r_ub_n, r_lb_n);
        addr[0] = l_addr;
        addr[1] = r_addr;
    end

    for (genvar p = 0; p < 2; p++) begin : g_side
        tp_port_track #(.ADDR_W(ADDR_W)) u_track (
            .clk     (clk),
            .rst     (rst),
            .en      (ctl[p].en),
            .addr    (addr[p]),
            .settled (settled[p])
        );
    end

    tp_arbiter u_arb (
        .clk       (clk),
        .rst       (rst),
        .master    (is_master),
        .l_en      (ctl[0].en),
        .r_en      (ctl[1].en),
        .l_wr      (ctl[0].wr),
        .r_wr      (ctl[1].wr),
        .same_addr (l_addr == r_addr),
        .l_settled (settled[0]),
        .r_settled (settled[1]),
        .l_lose    (l_lose),
        .r_lose    (r_lose)
    );

    assign l_busy_o = l_lose;
    assign r_busy_o = r_lose;
    assign l_block  = is_master ? l_lose : l_busy_i;
    assign r_block  = is_master ? r_lose : r_busy_i;

    tp_byte_mem #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_mem (
        .clk     (clk),
        .rst     (rst),
        .l_we    (ctl[0].en && ctl[0].wr && !l_block),
        .l_mask  (ctl[0].lanes),
        .l_addr  (l_addr),
        .l_wdata (l_wdata),
        .l_rdata (l_rdata),
        .r_we    (ctl[1].en && ctl[1].wr && !r_block),
        .r_mask  (ctl[1].lanes),
        .r_addr  (r_addr),
        .r_wdata (r_wdata),
        .r_rdata (r_rdata)
    );

    // R3: never both sides flagged
    assert_onehot_busy_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({l_busy_o, r_busy_o}));

    // R6: a busy flag needs both ports enabled on one address
    assert_busy_needs_match_R6: assert property (@(posedge clk) disable iff (rst)
        (l_busy_o || r_busy_o) |-> (!l_ce_n && !r_ce_n && (l_addr == r_addr)));

    // R2: shared reads never raise busy
    assert_read_share_R2: assert property (@(posedge clk) disable iff (rst)
        (!l_ce_n && !r_ce_n && !l_write && !r_write) |-> !(l_busy_o || r_busy_o));

    // R8: slave role leaves busy outputs low
    assert_slave_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !is_master |-> !(l_busy_o || r_busy_o));
endmodule

// File: tb/twin_port_guard_test.sv
module twin_port_guard_test;
    localparam int CLK_P = 10;
    localparam int AW    = 6;
    localparam int LW    = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic is_master = 1'b1;
    logic l_ce_n = 1'b1, l_write = 1'b0, l_ub_n = 1'b1, l_lb_n = 1'b1, l_busy_i = 1'b0;
    logic r_ce_n = 1'b1, r_write = 1'b0, r_ub_n = 1'b1, r_lb_n = 1'b1, r_busy_i = 1'b0;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic [2*LW-1:0] l_wdata = '0, r_wdata = '0;
    logic [2*LW-1:0] l_rdata, r_rdata;
    logic l_busy_o, r_busy_o;

    twin_port_guard #(.ADDR_W(AW), .LANE_W(LW)) uut (.*);

    always #(CLK_P/2) clk = ~clk;

    // reference model state
    logic [15:0] mdl [64];
    bit  pl_en, pr_en;
    logic [AW-1:0] pl_a, pr_a;
    int  own;
    int  checks = 0, fails = 0;
    bit  done = 0;

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish (actual hung, expected done)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    task automatic cyc(input string tag);
        bit lce, rce, cont, lold, rold, ebl, ebr, lblk, rblk;
        int win;
        logic [15:0] el, er;
        #(CLK_P/4);
        lce  = !l_ce_n;
        rce  = !r_ce_n;
        cont = lce && rce && (l_addr == r_addr) && (l_write || r_write);
        lold = lce && pl_en && (pl_a == l_addr);
        rold = rce && pr_en && (pr_a == r_addr);
        if (!cont)              win = 0;
        else if (own != 0)      win = own;
        else if (rold && !lold) win = 2;
        else                    win = 1;
        ebl = is_master && (win == 2);
        ebr = is_master && (win == 1);
        el  = mdl[l_addr];
        er  = mdl[r_addr];
        if (!rst) begin
            checks++;
            if (l_busy_o !== ebl || r_busy_o !== ebr || l_rdata !== el || r_rdata !== er) begin
                fails++;
                $display("FAIL %s t=%0t: busy L/R act %b%b exp %b%b rdata L act %h exp %h R act %h exp %h",
                         tag, $time, l_busy_o, r_busy_o, ebl, ebr, l_rdata, el, r_rdata, er);
            end
        end
        @(posedge clk);
        if (rst) begin
            for (int i = 0; i < 64; i++) mdl[i] = '0;
            pl_en = 0; pr_en = 0; pl_a = '0; pr_a = '0; own = 0;
        end else begin
            lblk = is_master ? ebl : l_busy_i;
            rblk = is_master ? ebr : r_busy_i;
            if (lce && l_write && !lblk) begin
                if (!l_ub_n) mdl[l_addr][15:8] = l_wdata[15:8];
                if (!l_lb_n) mdl[l_addr][7:0]  = l_wdata[7:0];
            end
            if (rce && r_write && !rblk) begin
                if (!r_ub_n) mdl[r_addr][15:8] = r_wdata[15:8];
                if (!r_lb_n) mdl[r_addr][7:0]  = r_wdata[7:0];
            end
            pl_en = lce; pl_a = l_addr;
            pr_en = rce; pr_a = r_addr;
            own = win;
        end
        @(negedge clk);
    endtask

    task automatic lset(input bit en, input bit wr, input int a, input logic [15:0] d,
                        input bit ub = 1, input bit lb = 1);
        l_ce_n = !en; l_write = wr; l_addr = a[AW-1:0]; l_wdata = d; l_ub_n = !ub; l_lb_n = !lb;
    endtask

    task automatic rset(input bit en, input bit wr, input int a, input logic [15:0] d,
                        input bit ub = 1, input bit lb = 1);
        r_ce_n = !en; r_write = wr; r_addr = a[AW-1:0]; r_wdata = d; r_ub_n = !ub; r_lb_n = !lb;
    endtask

    initial begin
        @(negedge clk);
        cyc("R1"); cyc("R1");
        rst = 1'b0;
        // R1: cleared array, idle busy
        for (int a = 0; a < 8; a++) begin
            lset(1, 0, a, '0); rset(1, 0, 63 - a, '0);
            cyc("R1");
        end
        // R10: lane writes
        lset(1, 1, 5, 16'hA1B2);               rset(0, 0, 0, '0); cyc("R10");
        lset(1, 1, 6, 16'hC3D4, 0, 1);         cyc("R10");
        lset(1, 1, 7, 16'hE5F6, 1, 0);         cyc("R10");
        lset(0, 0, 0, '0); rset(1, 0, 6, '0);  cyc("R10");
        rset(1, 0, 7, '0);                     cyc("R10");
        // R2 / R11: shared read
        lset(1, 0, 5, '0); rset(1, 0, 5, '0);
        repeat (3) cyc("R2");
        // R4: right enables on word left already holds; R7 blocked write
        lset(0, 0, 0, '0); rset(0, 0, 0, '0); cyc("R4");
        lset(1, 1, 9, 16'h1111);               cyc("R4");
        rset(1, 1, 9, 16'h2222);
        repeat (3) cyc("R4");
        lset(1, 0, 9, '0);                     cyc("R7");
        lset(0, 0, 0, '0);                     cyc("R6");
        rset(0, 0, 0, '0);                     cyc("R6");
        // R4: address-triggered, right settled first
        rset(1, 1, 12, 16'h3333); lset(1, 1, 3, 16'h4444); cyc("R4");
        lset(1, 1, 12, 16'h5555);
        repeat (2) cyc("R4");
        lset(1, 1, 13, 16'h5555);              cyc("R6");
        // R5: simultaneous start
        lset(0, 0, 0, '0); rset(0, 0, 0, '0);  cyc("R5");
        lset(1, 1, 20, 16'h6666); rset(1, 1, 20, 16'h7777);
        repeat (2) cyc("R5");
        // R7: busy reader sees stored word
        lset(0, 0, 0, '0); rset(0, 0, 0, '0);  cyc("R7");
        lset(1, 1, 5, 16'h8888);               cyc("R7");
        rset(1, 0, 5, '0);                     cyc("R7");
        lset(0, 0, 0, '0); rset(0, 0, 0, '0);  cyc("R7");
        // R8: slave role, external busy blocks writes
        is_master = 1'b0;
        l_busy_i = 1'b1; lset(1, 1, 30, 16'h9999); cyc("R8");
        l_busy_i = 1'b0; r_busy_i = 1'b1;
        lset(0, 0, 0, '0); rset(1, 1, 31, 16'hAAAA); cyc("R8");
        r_busy_i = 1'b0; rset(1, 0, 30, '0); lset(1, 0, 31, '0); cyc("R8");
        // R9: slave both write one word, right lanes win
        lset(1, 1, 32, 16'h1234); rset(1, 1, 32, 16'hABCD, 0, 1); cyc("R9");
        lset(1, 0, 32, '0); rset(0, 0, 0, '0); cyc("R9");
        // random traffic, both roles
        for (int m = 0; m < 2; m++) begin
            is_master = (m == 0);
            for (int n = 0; n < 400; n++) begin
                lset($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, $urandom_range(0, 3),
                     16'($urandom), $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);
                rset($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, $urandom_range(0, 3),
                     16'($urandom), $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);
                l_busy_i = (m == 1) && ($urandom_range(0, 3) == 0);
                r_busy_i = (m == 1) && ($urandom_range(0, 3) == 0);
                cyc("R3");
            end
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule